// File: doc/BRIEF.md
# Prefetch Address Translation Front End

This block sits between a prefetch kernel dispatcher and the prefetch cache. It accepts virtual prefetch addresses, holds them in a pending queue served oldest first, and translates the head entry to a physical address. Translation first checks a small fully associative first-level TLB. On a miss it checks a larger set-associative second-level TLB one cycle later. If both levels miss, it asks an external page-table walker for the mapping over a request/response pair. Translated requests leave as load prefetches on a one-cycle strobe.

Requests flagged as stores are discarded without translation. Requests whose walk reports a fault are discarded without any report to a core. A successful walk refills both TLB levels, and a second-level hit refills the first level. Only one walk is in flight at a time, and the queue head waits for its response. A flush input clears every translation in one cycle. Three counters tally translated, fault-dropped and store-dropped requests.

Top module: `pfx_xlat_front`

## Requirements
- R1: After reset the queue is empty, `reqReady` is 1, `pfValid` and `walkReqValid` are 0, and all three counters read 0.
- R2: The queue accepts a request when `reqValid` and `reqReady` are both high, and `reqReady` is low while it holds `Q_DEPTH` entries. A request offered while `reqReady` is low is ignored. Entries are served strictly in arrival order.
- R3: A head entry that hits the first-level TLB drives `pfValid` high in the cycle right after it is accepted. `pfPaddr` equals the stored page number concatenated with the 12-bit page offset (4 KiB pages) of the virtual address.
- R4: A first-level miss that hits the second-level TLB issues the prefetch one cycle later than a first-level hit. It also writes the translation into the first level, so the next access to that page hits there.
- R5: A miss in both levels raises `walkReqValid` with `walkReqVpn` equal to the virtual address bits 47:12. The request is held until `walkReqReady`, and at most one walk is outstanding while the queue head waits.
- R6: A walk response with `walkRespFault` low issues a prefetch in the response cycle with `pfPaddr = {walkRespPpn, offset}` and refills both TLB levels.
- R7: A walk response with `walkRespFault` high drops the request with no `pfValid` and installs no translation, so the same page walks again. `cntFaultDrop` increments.
- R8: A request with `reqIsStore` = 1 is dropped when it reaches the head, with no walk and no prefetch. `cntStoreDrop` increments.
- R9: The first-level TLB replaces entries round robin across all fills. The second-level TLB uses a round-robin victim pointer per set, and its set index is the low VPN bits.
- R10: A one-cycle `flush` invalidates both TLB levels. When flush coincides with a refill, the flush wins, but the prefetch of that cycle is still issued.
- R11: `cntTranslated` increments once for every issued prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate both TLB levels |
| reqValid | input | 1 | Incoming prefetch request valid |
| reqReady | output | 1 | Queue can accept a request |
| reqVaddr | input | 48 | Virtual prefetch address |
| reqIsStore | input | 1 | Request is a store (dropped) |
| walkReqValid | output | 1 | Page-table walk request |
| walkReqReady | input | 1 | Walker accepts the request |
| walkReqVpn | output | 36 | Virtual page number to walk |
| walkRespValid | input | 1 | Walk response valid |
| walkRespFault | input | 1 | Walk ended in a fault |
| walkRespPpn | input | 28 | Physical page number from the walk |
| pfValid | output | 1 | Load prefetch issued this cycle |
| pfPaddr | output | 40 | Physical prefetch address |
| cntTranslated | output | CNT_W | Issued prefetch count |
| cntFaultDrop | output | CNT_W | Fault-dropped count |
| cntStoreDrop | output | CNT_W | Store-dropped count |

## Verification
Two functions can land on the same clock edge: a walk response refilling both TLB levels and a flush clearing them. The bench waits until the walk response is visible, raises `flush` in that cycle, and confirms that the prefetch is still issued. It then sends the same page again and expects a full walk, with a four-cycle latency, because the flush must have won over the refill. A second overlap, a new arrival offered while a stalled walk keeps the queue full, is judged by counting the prefetches that later emerge.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [1:0] {SRC_L1, SRC_L2, SRC_WALK} ppnSrc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_L2, ST_WREQ, ST_WWAIT} xlatState_e;
  typedef struct packed {
    logic     pop;
    logic     l1Fill;
    logic     l2Fill;
    ppnSrc_e  src;
    logic     incXlat;
    logic     incFault;
    logic     incStore;
  } dpStb_t;
endpackage

// File: rtl/pfx_xlat_ctrl.sv
module pfx_xlat_ctrl
  import pfx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   qEmpty,
  input  logic   headStore,
  input  logic   l1Hit,
  input  logic   l2Hit,
  input  logic   walkReqReady,
  input  logic   walkRespValid,
  input  logic   walkRespFault,
  output logic   walkReqValid,
  output logic   pfValid,
  output dpStb_t stb
);
  xlatState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    stb          = '0;
    stb.src      = SRC_L1;
    pfValid      = 1'b0;
    walkReqValid = 1'b0;
    unique case (state)
      ST_IDLE: if (!qEmpty) begin
        if (headStore) begin
          stb.pop      = 1'b1;
          stb.incStore = 1'b1;
        end else if (l1Hit) begin
          stb.pop     = 1'b1;
          stb.incXlat = 1'b1;
          pfValid     = 1'b1;
        end else begin
          stateNxt = ST_L2;
        end
      end
      ST_L2: begin
        if (l2Hit) begin
          stb.pop     = 1'b1;
          stb.incXlat = 1'b1;
          stb.l1Fill  = 1'b1;
          stb.src     = SRC_L2;
          pfValid     = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          stateNxt = ST_WREQ;
        end
      end
      ST_WREQ: begin
        walkReqValid = 1'b1;
        if (walkReqReady) stateNxt = ST_WWAIT;
      end
      ST_WWAIT: if (walkRespValid) begin
        stb.pop  = 1'b1;
        stateNxt = ST_IDLE;
        if (walkRespFault) begin
          stb.incFault = 1'b1;
        end else begin
          stb.incXlat = 1'b1;
          stb.l1Fill  = 1'b1;
          stb.l2Fill  = 1'b1;
          stb.src     = SRC_WALK;
          pfValid     = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R5
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReqValid && !walkReqReady) |=> walkReqValid);

  // R5
  walk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(walkReqValid && pfValid));
endmodule

// File: rtl/pfx_xlat_dp.sv
module pfx_xlat_dp
  import pfx_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 40,
  parameter int PAGE_BITS  = 12,
  parameter int Q_DEPTH    = 128,
  parameter int L1_ENTRIES = 64,
  parameter int L2_SETS    = 256,
  parameter int L2_WAYS    = 4,
  parameter int CNT_W      = 32,
  localparam int VPN_W     = VA_W - PAGE_BITS,
  localparam int PPN_W     = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqIsStore,
  output logic             reqReady,
  input  dpStb_t           stb,
  input  logic [PPN_W-1:0] walkRespPpn,
  output logic             qEmpty,
  output logic             headStore,
  output logic             l1Hit,
  output logic             l2Hit,
  output logic [VPN_W-1:0] headVpn,
  output logic [PA_W-1:0]  pfPaddr,
  output logic [CNT_W-1:0] cntTranslated,
  output logic [CNT_W-1:0] cntFaultDrop,
  output logic [CNT_W-1:0] cntStoreDrop
);
  localparam int QP_W   = $clog2(Q_DEPTH);
  localparam int L1P_W  = $clog2(L1_ENTRIES);
  localparam int IDX_W  = $clog2(L2_SETS);
  localparam int TAG_W  = VPN_W - IDX_W;
  localparam int WAY_W  = $clog2(L2_WAYS);

  // pending queue, served oldest first
  logic [VA_W:0]   qMem [Q_DEPTH];
  logic [QP_W-1:0] wrPtr, rdPtr;
  logic [QP_W:0]   qCount;
  logic            push;

  assign reqReady  = (qCount != (QP_W+1)'(Q_DEPTH));
  assign qEmpty    = (qCount == '0);
  assign push      = reqValid && reqReady;
  assign headStore = qMem[rdPtr][VA_W];
  assign headVpn   = qMem[rdPtr][VA_W-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (push)    wrPtr <= wrPtr + QP_W'(1);
      if (stb.pop) rdPtr <= rdPtr + QP_W'(1);
      qCount <= qCount + (QP_W+1)'(push) - (QP_W+1)'(stb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) qMem[wrPtr] <= {reqIsStore, reqVaddr};
  end

  // first-level TLB, fully associative
  logic             l1Valid [L1_ENTRIES];
  logic [VPN_W-1:0] l1Vpn   [L1_ENTRIES];
  logic [PPN_W-1:0] l1Ppn   [L1_ENTRIES];
  logic [L1P_W-1:0] l1Rr;
  logic [PPN_W-1:0] l1HitPpn;

  always_comb begin
    l1Hit    = 1'b0;
    l1HitPpn = '0;
    for (int i = 0; i < L1_ENTRIES; i++) begin
      if (l1Valid[i] && l1Vpn[i] == headVpn) begin
        l1Hit    = 1'b1;
        l1HitPpn = l1Ppn[i];
      end
    end
  end

  // second-level TLB, set associative
  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] headTag;
  logic [L2_WAYS-1:0] l2Valid [L2_SETS];
  logic [TAG_W-1:0] l2Tag [L2_SETS][L2_WAYS];
  logic [PPN_W-1:0] l2Ppn [L2_SETS][L2_WAYS];
  logic [WAY_W-1:0] l2Rr  [L2_SETS];
  logic [PPN_W-1:0] l2HitPpn;

  assign setIdx  = headVpn[IDX_W-1:0];
  assign headTag = headVpn[VPN_W-1:IDX_W];

  always_comb begin
    l2Hit    = 1'b0;
    l2HitPpn = '0;
    for (int w = 0; w < L2_WAYS; w++) begin
      if (l2Valid[setIdx][w] && l2Tag[setIdx][w] == headTag) begin
        l2Hit    = 1'b1;
        l2HitPpn = l2Ppn[setIdx][w];
      end
    end
  end

  logic [PPN_W-1:0] selPpn, fillPpn;
  always_comb begin
    unique case (stb.src)
      SRC_L2:   selPpn = l2HitPpn;
      SRC_WALK: selPpn = walkRespPpn;
      default:  selPpn = l1HitPpn;
    endcase
  end
  assign fillPpn = selPpn;
  assign pfPaddr = {selPpn, qMem[rdPtr][PAGE_BITS-1:0]};

  // valid bits and victim pointers; flush takes priority over refill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1Rr <= '0;
      for (int i = 0; i < L1_ENTRIES; i++) l1Valid[i] <= 1'b0;
      for (int s = 0; s < L2_SETS; s++) begin
        l2Valid[s] <= '0;
        l2Rr[s]    <= '0;
      end
    end else if (flush) begin
      for (int i = 0; i < L1_ENTRIES; i++) l1Valid[i] <= 1'b0;
      for (int s = 0; s < L2_SETS; s++) l2Valid[s] <= '0;
    end else begin
      if (stb.l1Fill) begin
        l1Valid[l1Rr] <= 1'b1;
        l1Rr          <= l1Rr + L1P_W'(1);
      end
      if (stb.l2Fill) begin
        l2Valid[setIdx][l2Rr[setIdx]] <= 1'b1;
        l2Rr[setIdx]                  <= l2Rr[setIdx] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.l1Fill) begin
      l1Vpn[l1Rr] <= headVpn;
      l1Ppn[l1Rr] <= fillPpn;
    end
    if (stb.l2Fill) begin
      l2Tag[setIdx][l2Rr[setIdx]] <= headTag;
      l2Ppn[setIdx][l2Rr[setIdx]] <= fillPpn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntTranslated <= '0;
      cntFaultDrop  <= '0;
      cntStoreDrop  <= '0;
    end else begin
      if (stb.incXlat)  cntTranslated <= cntTranslated + CNT_W'(1);
      if (stb.incFault) cntFaultDrop  <= cntFaultDrop + CNT_W'(1);
      if (stb.incStore) cntStoreDrop  <= cntStoreDrop + CNT_W'(1);
    end
  end

  // R2
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qEmpty |-> !stb.pop);

  // R2
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qCount <= (QP_W+1)'(Q_DEPTH));

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!l1Hit && !l2Hit));

  // R11
  xlat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.incXlat |=> cntTranslated == $past(cntTranslated) + CNT_W'(1));
endmodule

// File: rtl/pfx_xlat_front.sv
module pfx_xlat_front
  import pfx_pkg::*;
#(
  parameter int Q_DEPTH    = 128,
  parameter int L1_ENTRIES = 64,
  parameter int L2_SETS    = 256,
  parameter int L2_WAYS    = 4,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [47:0]      reqVaddr,
  input  logic             reqIsStore,
  output logic             walkReqValid,
  input  logic             walkReqReady,
  output logic [35:0]      walkReqVpn,
  input  logic             walkRespValid,
  input  logic             walkRespFault,
  input  logic [27:0]      walkRespPpn,
  output logic             pfValid,
  output logic [39:0]      pfPaddr,
  output logic [CNT_W-1:0] cntTranslated,
  output logic [CNT_W-1:0] cntFaultDrop,
  output logic [CNT_W-1:0] cntStoreDrop
);
  dpStb_t stb;
  logic   qEmpty, headStore, l1Hit, l2Hit;

  pfx_xlat_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .qEmpty       (qEmpty),
    .headStore    (headStore),
    .l1Hit        (l1Hit),
    .l2Hit        (l2Hit),
    .walkReqReady (walkReqReady),
    .walkRespValid(walkRespValid),
    .walkRespFault(walkRespFault),
    .walkReqValid (walkReqValid),
    .pfValid      (pfValid),
    .stb          (stb)
  );

  pfx_xlat_dp #(
    .VA_W      (48),
    .PA_W      (40),
    .PAGE_BITS (12),
    .Q_DEPTH   (Q_DEPTH),
    .L1_ENTRIES(L1_ENTRIES),
    .L2_SETS   (L2_SETS),
    .L2_WAYS   (L2_WAYS),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .reqValid     (reqValid),
    .reqVaddr     (reqVaddr),
    .reqIsStore   (reqIsStore),
    .reqReady     (reqReady),
    .stb          (stb),
    .walkRespPpn  (walkRespPpn),
    .qEmpty       (qEmpty),
    .headStore    (headStore),
    .l1Hit        (l1Hit),
    .l2Hit        (l2Hit),
    .headVpn      (walkReqVpn),
    .pfPaddr      (pfPaddr),
    .cntTranslated(cntTranslated),
    .cntFaultDrop (cntFaultDrop),
    .cntStoreDrop (cntStoreDrop)
  );
endmodule

// File: tb/pfx_xlat_front_tb.sv
`timescale 1ns/1ps
module pfx_xlat_front_tb;
  localparam int CW = 16;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic reqValid = 1'b0;
  logic [47:0] reqVaddr = '0;
  logic reqIsStore = 1'b0;
  logic wReady = 1'b1;
  logic walkRespValid = 1'b0;
  logic walkRespFault = 1'b0;
  logic [27:0] walkRespPpn = '0;
  logic reqReady, walkReqValid, pfValid;
  logic [35:0] walkReqVpn;
  logic [39:0] pfPaddr;
  logic [CW-1:0] cntTranslated, cntFaultDrop, cntStoreDrop;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic accPend = 1'b0;
  logic [35:0] accVpn = '0;

  always #2.5 clk = ~clk;

  pfx_xlat_front #(.Q_DEPTH(4), .L1_ENTRIES(4), .L2_SETS(8), .L2_WAYS(4), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqIsStore(reqIsStore), .walkReqValid(walkReqValid),
    .walkReqReady(wReady), .walkReqVpn(walkReqVpn), .walkRespValid(walkRespValid),
    .walkRespFault(walkRespFault), .walkRespPpn(walkRespPpn), .pfValid(pfValid),
    .pfPaddr(pfPaddr), .cntTranslated(cntTranslated), .cntFaultDrop(cntFaultDrop),
    .cntStoreDrop(cntStoreDrop));

  function automatic logic [27:0] ppnOf(logic [35:0] vpn);
    return vpn[27:0] ^ 28'h5A5A5A5;
  endfunction
  function automatic logic isFault(logic [35:0] vpn);
    return vpn[20];
  endfunction

  // walker model: accept seen at negedge, respond one cycle after the handshake edge
  always @(negedge clk) begin
    if (walkReqValid && wReady) begin
      accPend <= 1'b1;
      accVpn  <= walkReqVpn;
    end
  end
  always @(posedge clk) begin
    #1;
    walkRespValid = accPend;
    walkRespFault = isFault(accVpn);
    walkRespPpn   = ppnOf(accVpn);
    accPend       = 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // vector table: page, store flag, expected latency (0 = none), expected walks
  localparam logic [35:0] V_VPN [NV] = '{36'h10, 36'h10, 36'h11, 36'h11, 36'h12, 36'h13,
                                         36'h14, 36'h10, 36'h11, 36'h14, 36'h100010, 36'h100010};
  localparam bit V_ST [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_K  [NV] = '{4, 1, 0, 4, 4, 4, 4, 2, 2, 1, 0, 0};
  localparam int V_W  [NV] = '{1, 0, 0, 1, 1, 1, 1, 0, 0, 0, 1, 1};

  function automatic string reqOf(int i);
    case (i)
      1, 9:   return "R3";
      2:      return "R8";
      7, 8:   return "R4_R9";
      10, 11: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic runOne(input logic [47:0] va, input logic st, input int expK,
                        input int expW, input string req);
    int k = 0;
    int walks = 0;
    logic [39:0] pa = '0;
    reqVaddr = va; reqIsStore = st; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 1; n <= 8; n++) begin
      if (n > 1) @(negedge clk);
      if (walkReqValid && wReady) begin
        walks++;
        check({req, "_R5_vpn"}, 64'(walkReqVpn), 64'(va[47:12]));
      end
      if (pfValid && k == 0) begin k = n; pa = pfPaddr; end
    end
    check({req, "_lat"}, 64'(k), 64'(expK));
    check({req, "_R5_walks"}, 64'(walks), 64'(expW));
    if (expK != 0) check({req, "_paddr"}, 64'(pa), 64'({ppnOf(va[47:12]), va[11:0]}));
  endtask

  initial begin
    logic [39:0] got [8];
    int nGot;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1_ready", 64'(reqReady), 64'd1);
    check("R1_pf", 64'(pfValid), 64'd0);
    check("R1_walk", 64'(walkReqValid), 64'd0);
    check("R1_cnt", 64'({cntTranslated, cntFaultDrop, cntStoreDrop}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      runOne({V_VPN[i], 12'(i * 64 + 4)}, V_ST[i], V_K[i], V_W[i], reqOf(i));

    // R2 queue fills behind a stalled walk; extra arrival ignored; order kept
    wReady = 1'b0;
    for (int i = 0; i < 5; i++) begin
      reqVaddr = {36'h200 + 36'(i), 12'h08}; reqIsStore = 1'b0; reqValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (i == 3) check("R2_full", 64'(reqReady), 64'd0);
    end
    reqValid = 1'b0;
    nGot = 0;
    wReady = 1'b1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (pfValid && nGot < 8) begin got[nGot] = pfPaddr; nGot++; end
    end
    check("R2_count", 64'(nGot), 64'd4);
    check("R2_first", 64'(got[0]), 64'({ppnOf(36'h200), 12'h08}));
    check("R2_last", 64'(got[3]), 64'({ppnOf(36'h203), 12'h08}));

    // R10 plain flush: a page held in L1 must walk again
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    runOne({36'h203, 12'h10}, 1'b0, 4, 1, "R10_flush");

    // R10 flush in the same cycle as a walk refill
    reqVaddr = {36'h300, 12'h20}; reqIsStore = 1'b0; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 8 && !walkRespValid; n++) @(negedge clk);
    flush = 1'b1;
    check("R10_pf_kept", 64'(pfValid), 64'd1);
    @(negedge clk);
    flush = 1'b0;
    runOne({36'h300, 12'h24}, 1'b0, 4, 1, "R10_coincide");

    // R7 R8 R11 counters
    check("R11_xlat", 64'(cntTranslated), 64'd16);
    check("R7_fault", 64'(cntFaultDrop), 64'd2);
    check("R8_store", 64'(cntStoreDrop), 64'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule